// File: doc/BRIEF.md
# Two-Port Shared RAM Access Arbiter

This block lets two independent requesters, port A and port B, share one single-port synchronous RAM. Each port can raise a read request or a write enable for a single clock, and may do so in the same cycle as the other port. Every request is captured into a small per-port queue. The arbiter then issues the queued requests to the RAM at a rate of one access per cycle. When both ports have work waiting, it alternates between them, and it routes each read result back to the port that asked for it.

A queue passes a request straight through in the cycle it arrives when nothing is ahead of it, so an uncontested request reaches the RAM with no added delay. Each issued read carries a one-bit port tag down a short pipeline that matches the RAM's fixed read latency. The returning data is registered once into the owning port's output, together with a one-cycle valid strobe. If a port sends a request while its queue is full and cannot drain in that cycle, the request is dropped and a sticky per-port overflow flag is raised.

Top module: `ram_share_arb`

## Requirements
- R1: Every request pulse, even one clock wide, produces exactly one RAM access while its queue is not overflowing. A read and a write are never issued in the same cycle.
- R2: Requests raised by port A and port B in the same cycle both complete, and each write lands at its address.
- R3: When both ports have a request pending, the grants alternate between them, and the first contested grant after reset goes to port A.
- R4: A request that arrives at an empty queue, with the other port idle, drives the RAM access strobe, address and write data combinationally in that same cycle.
- R5: A read issued in cycle t returns on the issuing port's read data in cycle t+3 (RAM latency 2 plus one output register). The read-valid strobe is high for exactly that one cycle, and the other port's strobe stays low.
- R6: The requests of one port reach the RAM in the order that port raised them, so a read that follows a write to the same address returns the written data.
- R7: When both ports raise reads on two consecutive cycles, all four reads are served and reach the RAM in the order A, B, A, B.
- R8: A request that arrives while its port's queue holds three entries, and no entry leaves that cycle, is dropped. It sets that port's overflow flag, which stays high until reset.
- R9: While reset is applied and after it is released, the RAM strobes, both read-valid strobes and both overflow flags are low.
- R10: When a port raises its write enable and its read request in the same cycle, only the write is queued and no read data is returned for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aRdReq | input | 1 | Port A read request pulse |
| aWrEn | input | 1 | Port A write enable pulse; overrides aRdReq |
| aAddr | input | ADDR_W | Port A address |
| aWrData | input | DATA_W | Port A write data |
| aRdData | output | DATA_W | Port A returned read data |
| aRdValid | output | 1 | Port A read data valid, one cycle per read |
| aOverflow | output | 1 | Port A sticky dropped-request flag |
| bRdReq | input | 1 | Port B read request pulse |
| bWrEn | input | 1 | Port B write enable pulse; overrides bRdReq |
| bAddr | input | ADDR_W | Port B address |
| bWrData | input | DATA_W | Port B write data |
| bRdData | output | DATA_W | Port B returned read data |
| bRdValid | output | 1 | Port B read data valid, one cycle per read |
| bOverflow | output | 1 | Port B sticky dropped-request flag |
| ramRdEn | output | 1 | RAM read strobe |
| ramWrEn | output | 1 | RAM write strobe |
| ramAddr | output | ADDR_W | RAM address |
| ramWrData | output | DATA_W | RAM write data |
| ramRdData | input | DATA_W | RAM read data, valid RD_LAT cycles after a read strobe |

## Verification
The bench builds the block with 8-bit address and data, queues three entries deep and a read latency of two cycles, and pairs it with a bench RAM model of the same latency. The shallow queue lets two ports that request on every cycle reach overflow within about eight cycles, which brings the sticky flag and the dropping of requests into reach. The 8-bit address space is split into one region per port, so the expected read data follows from each port's own order alone. The two-cycle latency keeps the tag pipeline, the interleaved issue and the return timing short enough to check cycle by cycle.

// File: rtl/ram_share_pkg.sv
package ram_share_pkg;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } portSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     pushA;
    logic     pushB;
    logic     issue;
    portSel_e sel;
  } ctrlStrobe_t;

  // Queue status from datapath to control
  typedef struct packed {
    logic storedA;
    logic storedB;
    logic fullA;
    logic fullB;
  } queueStat_t;

endpackage

// File: rtl/ram_share_fifo.sv
module ram_share_fifo #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic             stored,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic isEmpty, doWrite, doRead;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign isEmpty = (count == '0);
  // an entry pushed into an empty queue and popped in the same cycle is never stored
  assign doWrite = push && !(pop && isEmpty);
  assign doRead  = pop && !isEmpty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= nextPtr(wrPtr);
      if (doRead)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doWrite) - CNT_W'(doRead);
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) slots[wrPtr] <= pushData;
  end

  assign headData = isEmpty ? pushData : slots[rdPtr];
  assign stored   = !isEmpty;
  assign full     = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/ram_share_ctrl.sv
module ram_share_ctrl
  import ram_share_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqA,
  input  logic        reqB,
  input  queueStat_t  stat,
  output ctrlStrobe_t strobe,
  output logic        ovfA,
  output logic        ovfB
);
  logic     lastB;
  logic     headA, headB, issue, popA, popB, pushA, pushB;
  portSel_e sel;

  always_comb begin
    headA = stat.storedA | reqA;
    headB = stat.storedB | reqB;
    if (headA && headB) sel = lastB ? SEL_A : SEL_B;
    else                sel = headB ? SEL_B : SEL_A;
    issue = headA | headB;
    popA  = issue && (sel == SEL_A);
    popB  = issue && (sel == SEL_B);
    // a full queue still accepts when its head leaves this cycle
    pushA = reqA && (!stat.fullA || popA);
    pushB = reqB && (!stat.fullB || popB);
  end

  assign strobe = '{pushA: pushA, pushB: pushB, issue: issue, sel: sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      lastB <= 1'b1;
      ovfA  <= 1'b0;
      ovfB  <= 1'b0;
    end else begin
      if (issue) lastB <= (sel == SEL_B);
      ovfA <= ovfA | (reqA & ~pushA);
      ovfB <= ovfB | (reqB & ~pushB);
    end
  end

endmodule

// File: rtl/ram_share_dp.sv
module ram_share_dp
  import ram_share_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 3,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aWrEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  input  logic              bWrEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  input  ctrlStrobe_t       strobe,
  output queueStat_t        stat,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] aRdData,
  output logic              aRdValid,
  output logic [DATA_W-1:0] bRdData,
  output logic              bRdValid
);
  localparam int ENTRY_W = 1 + ADDR_W + DATA_W;
  localparam int NPORT   = 2;

  logic [NPORT-1:0][ENTRY_W-1:0] reqEntry, headEntry;
  logic [NPORT-1:0] qPush, qPop, qStored, qFull;
  logic [ENTRY_W-1:0] issued;
  logic [RD_LAT-1:0] tagValid, tagPort;
  logic retValid, retPort;

  assign reqEntry[0] = {aWrEn, aAddr, aWrData};
  assign reqEntry[1] = {bWrEn, bAddr, bWrData};
  assign qPush = {strobe.pushB, strobe.pushA};
  assign qPop  = {strobe.issue && (strobe.sel == SEL_B),
                  strobe.issue && (strobe.sel == SEL_A)};

  for (genvar p = 0; p < NPORT; p++) begin : g_queue
    ram_share_fifo #(.WIDTH(ENTRY_W), .DEPTH(QDEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .push    (qPush[p]),
      .pop     (qPop[p]),
      .pushData(reqEntry[p]),
      .headData(headEntry[p]),
      .stored  (qStored[p]),
      .full    (qFull[p])
    );
  end

  assign stat = '{storedA: qStored[0], storedB: qStored[1],
                  fullA: qFull[0], fullB: qFull[1]};

  assign issued    = (strobe.sel == SEL_B) ? headEntry[1] : headEntry[0];
  assign ramWrEn   = strobe.issue &  issued[ENTRY_W-1];
  assign ramRdEn   = strobe.issue & ~issued[ENTRY_W-1];
  assign ramAddr   = issued[ENTRY_W-2 -: ADDR_W];
  assign ramWrData = issued[DATA_W-1:0];

  // port tag pipeline aligned to the RAM read latency
  for (genvar s = 0; s < RD_LAT; s++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst) begin
        tagValid[s] <= 1'b0;
        tagPort[s]  <= 1'b0;
      end else if (s == 0) begin
        tagValid[s] <= ramRdEn;
        tagPort[s]  <= strobe.sel;
      end else begin
        tagValid[s] <= tagValid[(s > 0) ? s - 1 : 0];
        tagPort[s]  <= tagPort[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign retValid = tagValid[RD_LAT-1];
  assign retPort  = tagPort[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      aRdValid <= 1'b0;
      bRdValid <= 1'b0;
      aRdData  <= '0;
      bRdData  <= '0;
    end else begin
      aRdValid <= retValid & ~retPort;
      bRdValid <= retValid &  retPort;
      if (retValid & ~retPort) aRdData <= ramRdData;
      if (retValid &  retPort) bRdData <= ramRdData;
    end
  end

endmodule

// File: rtl/ram_share_arb.sv
module ram_share_arb
  import ram_share_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 3,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aRdReq,
  input  logic              aWrEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  output logic              aRdValid,
  output logic              aOverflow,
  input  logic              bRdReq,
  input  logic              bWrEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  output logic              bRdValid,
  output logic              bOverflow,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData
);
  ctrlStrobe_t strobe;
  queueStat_t  stat;

  ram_share_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .reqA  (aRdReq | aWrEn),
    .reqB  (bRdReq | bWrEn),
    .stat  (stat),
    .strobe(strobe),
    .ovfA  (aOverflow),
    .ovfB  (bOverflow)
  );

  ram_share_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH), .RD_LAT(RD_LAT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .aWrEn    (aWrEn),
    .aAddr    (aAddr),
    .aWrData  (aWrData),
    .bWrEn    (bWrEn),
    .bAddr    (bAddr),
    .bWrData  (bWrData),
    .strobe   (strobe),
    .stat     (stat),
    .ramRdEn  (ramRdEn),
    .ramWrEn  (ramWrEn),
    .ramAddr  (ramAddr),
    .ramWrData(ramWrData),
    .ramRdData(ramRdData),
    .aRdData  (aRdData),
    .aRdValid (aRdValid),
    .bRdData  (bRdData),
    .bRdValid (bRdValid)
  );

endmodule

// File: rtl/ram_share_chk.sv
module ram_share_chk #(
  parameter int RD_LAT = 2
) (
  input logic clk,
  input logic rst,
  input logic ramRdEn,
  input logic ramWrEn,
  input logic aRdValid,
  input logic bRdValid,
  input logic aOverflow,
  input logic bOverflow
);
  // history of read strobes: bit k is the strobe k+1 cycles ago
  logic [RD_LAT:0] rdHist;

  always_ff @(posedge clk) begin
    if (rst) rdHist <= '0;
    else     rdHist <= {rdHist[RD_LAT-1:0], ramRdEn};
  end

  a_r1_one_access: assert property (@(posedge clk) disable iff (rst)
    !(ramRdEn && ramWrEn));

  a_r5_return_timing: assert property (@(posedge clk) disable iff (rst)
    (aRdValid || bRdValid) |-> rdHist[RD_LAT]);

  a_r5_one_owner: assert property (@(posedge clk) disable iff (rst)
    !(aRdValid && bRdValid));

  a_r8_sticky_a: assert property (@(posedge clk) disable iff (rst)
    aOverflow |=> aOverflow);

  a_r8_sticky_b: assert property (@(posedge clk) disable iff (rst)
    bOverflow |=> bOverflow);

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> !aRdValid && !bRdValid && !aOverflow && !bOverflow);

endmodule

bind ram_share_arb ram_share_chk #(.RD_LAT(RD_LAT)) u_chk (.*);

// File: tb/ram_share_arb_tb.sv
module ram_share_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aRdReq = 0, aWrEn = 0, bRdReq = 0, bWrEn = 0;
  logic [7:0] aAddr = 0, aWrData = 0, bAddr = 0, bWrData = 0;
  logic [7:0] aRdData, bRdData, ramAddr, ramWrData, ramRdData;
  logic aRdValid, bRdValid, aOverflow, bOverflow, ramRdEn, ramWrEn;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ram_share_arb u_dut (
    .clk(clk), .rst(rst),
    .aRdReq(aRdReq), .aWrEn(aWrEn), .aAddr(aAddr), .aWrData(aWrData),
    .aRdData(aRdData), .aRdValid(aRdValid), .aOverflow(aOverflow),
    .bRdReq(bRdReq), .bWrEn(bWrEn), .bAddr(bAddr), .bWrData(bWrData),
    .bRdData(bRdData), .bRdValid(bRdValid), .bOverflow(bOverflow),
    .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramRdData(ramRdData)
  );

  // RAM model, read latency two cycles
  logic [7:0] ramMem [256];
  logic [7:0] ramStage;
  initial for (int i = 0; i < 256; i++) ramMem[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) begin
    if (ramWrEn) ramMem[ramAddr] <= ramWrData;
    ramStage  <= ramMem[ramAddr];
    ramRdData <= ramStage;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected state, per port in its own order
  logic [7:0] shadow [256];
  initial for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
  logic [7:0] expA [256];
  logic [7:0] expB [256];
  int expAWr = 0, expARd = 0, expBWr = 0, expBRd = 0;
  int reqCount = 0, accCount = 0, logN = 0;
  logic [7:0] logAddr [64];

  // stimulus: {aRd,aWr,aAddr,aData, bRd,bWr,bAddr,bData}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h05, 8'h11, 1'b0, 1'b1, 8'h85, 8'h22},
    {1'b1, 1'b0, 8'h05, 8'h00, 1'b1, 1'b0, 8'h85, 8'h00},
    36'h0,
    {1'b1, 1'b0, 8'h06, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h06, 8'h33, 1'b1, 1'b0, 8'h86, 8'h00},
    {1'b1, 1'b0, 8'h06, 8'h00, 1'b0, 1'b1, 8'h86, 8'h44},
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h86, 8'h00},
    36'h0,
    {1'b0, 1'b1, 8'h07, 8'h55, 1'b0, 1'b1, 8'h87, 8'h66},
    {1'b1, 1'b0, 8'h07, 8'h00, 1'b1, 1'b0, 8'h87, 8'h00},
    {1'b1, 1'b0, 8'h05, 8'h00, 1'b1, 1'b0, 8'h85, 8'h00},
    36'h0
  };

  task automatic drv(input logic [35:0] v);
    @(posedge clk); #1;
    {aRdReq, aWrEn, aAddr, aWrData, bRdReq, bWrEn, bAddr, bWrData} = v;
    if (v[34]) shadow[v[33:26]] = v[25:18];
    else if (v[35]) begin expA[expAWr[7:0]] = shadow[v[33:26]]; expAWr++; end
    if (v[16]) shadow[v[15:8]] = v[7:0];
    else if (v[17]) begin expB[expBWr[7:0]] = shadow[v[15:8]]; expBWr++; end
    if (v[35] | v[34]) reqCount++;
    if (v[17] | v[16]) reqCount++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(36'h0);
  endtask

  task automatic doReset();
    @(posedge clk); #1; rst = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
  endtask

  // monitor: return routing and RAM access log
  always @(negedge clk) begin
    if (!rst) begin
      if (ramRdEn | ramWrEn) begin
        accCount++;
        if (logN < 64) logAddr[logN] = ramAddr;
        logN++;
      end
      if (aRdValid) begin
        chk(expARd < expAWr, "R5 unexpected port A return", 1, 0);
        chk(aRdData == expA[expARd[7:0]], "R5 R6 port A data", aRdData, expA[expARd[7:0]]);
        expARd++;
      end
      if (bRdValid) begin
        chk(expBRd < expBWr, "R5 unexpected port B return", 1, 0);
        chk(bRdData == expB[expBRd[7:0]], "R5 R6 port B data", bRdData, expB[expBRd[7:0]]);
        expBRd++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ramRdEn && !ramWrEn && !aRdValid && !bRdValid, "R9 quiet in reset", 1, 0);
    #1; rst = 1'b0;
    @(negedge clk);
    chk(!aRdValid && !bRdValid && !aOverflow && !bOverflow, "R9 quiet after reset", 0, 0);

    // vector table: concurrent pulses, ordering, routing
    for (int i = 0; i < NVEC; i++) drv(VEC[i]);
    idle(10);
    chk(accCount == reqCount, "R1 access count", accCount, reqCount);
    chk(expARd == expAWr, "R1 R2 port A reads served", expARd, expAWr);
    chk(expBRd == expBWr, "R1 R2 port B reads served", expBRd, expBWr);
    chk(ramMem[8'h06] == 8'h33 && ramMem[8'h86] == 8'h44, "R2 writes landed",
        {ramMem[8'h06], ramMem[8'h86]}, 16'h3344);
    chk(!aOverflow && !bOverflow, "R8 no overflow on light load", {aOverflow, bOverflow}, 0);

    // fall-through and return timing
    drv({1'b1, 1'b0, 8'h07, 8'h00, 18'h0});
    #2;
    chk(ramRdEn && ramAddr == 8'h07, "R4 same-cycle issue", ramAddr, 8'h07);
    drv(36'h0);
    @(negedge clk); chk(!aRdValid, "R5 not yet at t+1", aRdValid, 0);
    @(negedge clk); chk(!aRdValid, "R5 not yet at t+2", aRdValid, 0);
    @(negedge clk); chk(aRdValid && !bRdValid && aRdData == 8'h55, "R5 return at t+3", aRdData, 8'h55);
    @(negedge clk); chk(!aRdValid, "R5 strobe one cycle", aRdValid, 0);
    idle(4);

    // double read burst on both ports after reset
    doReset();
    logN = 0;
    drv({1'b1, 1'b0, 8'h10, 8'h00, 1'b1, 1'b0, 8'h90, 8'h00});
    drv({1'b1, 1'b0, 8'h11, 8'h00, 1'b1, 1'b0, 8'h91, 8'h00});
    idle(8);
    chk(logN == 4, "R7 four reads issued", logN, 4);
    chk(logAddr[0] == 8'h10, "R3 R7 first grant A", logAddr[0], 8'h10);
    chk(logAddr[1] == 8'h90, "R7 second grant B", logAddr[1], 8'h90);
    chk(logAddr[2] == 8'h11, "R7 third grant A", logAddr[2], 8'h11);
    chk(logAddr[3] == 8'h91, "R7 fourth grant B", logAddr[3], 8'h91);
    chk(expARd == expAWr && expBRd == expBWr, "R7 all four returned",
        expARd + expBRd, expAWr + expBWr);

    // write and read raised together
    logN = 0;
    drv({1'b1, 1'b1, 8'h30, 8'h77, 18'h0});
    idle(6);
    chk(logN == 1, "R10 single access", logN, 1);
    chk(ramMem[8'h30] == 8'h77, "R10 write performed", ramMem[8'h30], 8'h77);
    chk(expARd == expAWr, "R10 no read returned", expARd, expAWr);
    drv({1'b1, 1'b0, 8'h30, 8'h00, 18'h0});
    idle(5);
    chk(expARd == expAWr, "R10 readback served", expARd, expAWr);

    // overflow, sticky, reset clears
    doReset();
    for (int i = 0; i < 10; i++)
      drv({1'b0, 1'b1, 8'(8'h20 + i), 8'(i), 1'b0, 1'b1, 8'(8'hA0 + i), 8'(i)});
    drv(36'h0);
    @(negedge clk);
    chk(aOverflow && bOverflow, "R8 overflow raised", {aOverflow, bOverflow}, 2'b11);
    idle(10);
    @(negedge clk);
    chk(aOverflow && bOverflow, "R8 overflow sticky", {aOverflow, bOverflow}, 2'b11);
    doReset();
    @(negedge clk);
    chk(!aOverflow && !bOverflow, "R8 R9 reset clears overflow", {aOverflow, bOverflow}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule